// File: doc/BRIEF.md
# Oversampled Glitch and Burst Monitor

The monitor watches one line, typically the digital output of a supply-current sensor, for pulses narrower than a system clock period. A front end outside this block samples the line at several phases spread evenly across each clock period. It hands the block one vector of those samples per clock. Bit 0 is the earliest phase and the highest bit is the latest. Any high sample in a vector raises the per-cycle hit flag. Catching a pulse therefore depends only on the pulse being wider than one phase spacing, not on where it lands in the period.

The samples of successive cycles are treated as a single stream. Every 0-to-1 step in that stream counts as one new pulse, and this includes a step between the last phase of one cycle and the first phase of the next. A burst opens on the first cycle with a hit. It stays open while the hits keep arriving, and it closes after a programmable number of consecutive clocks with no hit. While the burst is open, the block reports the running pulse count and the burst span in clocks. When the burst closes, it issues a one-cycle completion strobe that carries the final figures, and then clears them. Both counters stop at their maximum value rather than wrapping.

Top module: `glitch_burst_monitor`

## Requirements
- R1: After reset, `hit`, `pulseCount`, `burstSpan` and `burstDone` are all zero.
- R2: `hit` equals the OR of all bits of the `phaseSamples` vector captured at the latest rising clock edge.
- R3: A vector with exactly one high bit, in any bit position, raises `hit` and, in an idle monitor, gives a pulse count of 1.
- R4: Within one captured vector, every bit i at 1 whose lower neighbour i-1 is 0 adds one to `pulseCount`. Bit 0 is the earliest phase.
- R5: Bit 0 of a vector is compared with the top bit of the previous vector. A 1 after a 0 counts as a pulse, and a 1 after a 1 continues the earlier pulse. The stored top bit is 0 after reset.
- R6: `burstSpan` is the number of clocks from the first hit cycle of the open burst to its latest hit cycle, both included. No-hit cycles inside the burst count toward it.
- R7: After `quietGap` consecutive no-hit cycles, `burstDone` is high for exactly one cycle, while `pulseCount` and `burstSpan` hold the final values. In the next cycle both are zero unless a new burst starts. A `quietGap` of 0 acts as 1.
- R8: `pulseCount` saturates at 2^CNT_W-1.
- R9: `burstSpan` saturates at 2^SPAN_W-1.
- R10: A hit in the cycle that shows `burstDone` starts a new burst. Its counts begin from that cycle's vector alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseSamples | input | PHASES | Oversampled line, bit 0 earliest phase |
| quietGap | input | GAP_W | No-hit clocks that close a burst (0 acts as 1) |
| hit | output | 1 | Some phase of the last vector was high |
| pulseCount | output | CNT_W | Pulses in the open or just closed burst |
| burstSpan | output | SPAN_W | Span of the burst in clocks |
| burstDone | output | 1 | One-cycle burst-complete strobe |

## Verification
Every result is registered once. `hit`, `pulseCount`, `burstSpan` and `burstDone` all reflect the vector captured at the latest rising edge, so they are due one edge after the vector is driven. The closing strobe appears at the edge that captures the gap-th quiet vector. The cleared counts appear one edge after that. The bench drives each vector on the falling edge and compares all four outputs shortly after the following rising edge, against a cycle model built from the requirements. Sweeps cover every single-cycle vector, pseudo-random streams under every gap setting, and directed saturation and restart cases.

// File: rtl/gbm_pkg.sv
package gbm_pkg;
  // Strobes from burst control to the counting datapath; at most one of
  // startBurst, extendBurst, quietTick and closeBurst is high in a cycle.
  typedef struct packed {
    logic startBurst;   // idle, hit now: load counters from this vector
    logic extendBurst;  // open burst, hit now: accumulate
    logic quietTick;    // open burst, no hit, gap not yet reached
    logic closeBurst;   // open burst, gap reached: hold final values
    logic clearCounts;  // cycle after close with no new start
  } ctrlStrobe_t;
endpackage

// File: rtl/gbm_control.sv
module gbm_control
  import gbm_pkg::*;
#(
  parameter int GAP_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             hitNow,
  input  logic [GAP_W-1:0] quietGap,
  output ctrlStrobe_t      strobes,
  output logic             burstDone
);
  logic             active;
  logic [GAP_W-1:0] quietCnt;
  logic [GAP_W:0]   gapEff;
  logic [GAP_W:0]   quietNext;
  logic             closeNow;

  always_comb begin
    gapEff    = (quietGap == '0) ? (GAP_W+1)'(1) : {1'b0, quietGap};
    quietNext = {1'b0, quietCnt} + (GAP_W+1)'(1);
    closeNow  = active && !hitNow && (quietNext >= gapEff);
    strobes.startBurst  = !active && hitNow;
    strobes.extendBurst = active && hitNow;
    strobes.quietTick   = active && !hitNow && !closeNow;
    strobes.closeBurst  = closeNow;
    strobes.clearCounts = burstDone && !strobes.startBurst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      quietCnt  <= '0;
      burstDone <= 1'b0;
    end else begin
      active    <= (active && !closeNow) || strobes.startBurst;
      burstDone <= closeNow;
      if (hitNow || closeNow) quietCnt <= '0;
      else if (strobes.quietTick) quietCnt <= quietNext[GAP_W-1:0];
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    burstDone |=> !burstDone); // R7
  AST_QUIET_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    active |-> ({1'b0, quietCnt} < gapEff)); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.startBurst, strobes.extendBurst, strobes.quietTick, strobes.closeBurst})); // R10
endmodule

// File: rtl/gbm_datapath.sv
module gbm_datapath
  import gbm_pkg::*;
#(
  parameter int PHASES = 10,
  parameter int CNT_W  = 8,
  parameter int SPAN_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] phaseSamples,
  input  ctrlStrobe_t       strobes,
  output logic              hitNow,
  output logic              hit,
  output logic [CNT_W-1:0]  pulseCount,
  output logic [SPAN_W-1:0] burstSpan
);
  localparam int EDGE_W = $clog2(PHASES + 1);
  localparam logic [CNT_W:0]  CNT_MAX  = {1'b0, {CNT_W{1'b1}}};
  localparam logic [SPAN_W:0] SPAN_MAX = {1'b0, {SPAN_W{1'b1}}};

  logic              prevLast;
  logic [PHASES-1:0] rise;
  logic [EDGE_W-1:0] edgeCount;
  logic [SPAN_W-1:0] spanCnt;
  logic [CNT_W:0]    pulseSum;
  logic [CNT_W-1:0]  pulseSat;
  logic [CNT_W-1:0]  edgeSat;
  logic [SPAN_W:0]   spanSum;
  logic [SPAN_W-1:0] spanSat;

  // One rising-step detector per phase; phase 0 looks back into last cycle.
  for (genvar i = 0; i < PHASES; i++) begin : g_rise
    if (i == 0) begin : g_first
      assign rise[i] = phaseSamples[i] & ~prevLast;
    end else begin : g_rest
      assign rise[i] = phaseSamples[i] & ~phaseSamples[i-1];
    end
  end

  always_comb begin
    edgeCount = '0;
    for (int i = 0; i < PHASES; i++) edgeCount = edgeCount + EDGE_W'(rise[i]);
    hitNow   = |phaseSamples;
    pulseSum = {1'b0, pulseCount} + (CNT_W+1)'(edgeCount);
    pulseSat = (pulseSum > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : pulseSum[CNT_W-1:0];
    edgeSat  = ((CNT_W+1)'(edgeCount) > CNT_MAX) ? CNT_MAX[CNT_W-1:0] : CNT_W'(edgeCount);
    spanSum  = {1'b0, spanCnt} + (SPAN_W+1)'(1);
    spanSat  = (spanSum > SPAN_MAX) ? SPAN_MAX[SPAN_W-1:0] : spanSum[SPAN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLast   <= 1'b0;
      hit        <= 1'b0;
      pulseCount <= '0;
      spanCnt    <= '0;
      burstSpan  <= '0;
    end else begin
      prevLast <= phaseSamples[PHASES-1];
      hit      <= hitNow;
      if (strobes.startBurst) begin
        pulseCount <= edgeSat;
        spanCnt    <= SPAN_W'(1);
        burstSpan  <= SPAN_W'(1);
      end else if (strobes.extendBurst) begin
        pulseCount <= pulseSat;
        spanCnt    <= spanSat;
        burstSpan  <= spanSat;
      end else if (strobes.quietTick) begin
        spanCnt    <= spanSat;
      end else if (strobes.clearCounts) begin
        pulseCount <= '0;
        spanCnt    <= '0;
        burstSpan  <= '0;
      end
    end
  end

  AST_PULSE_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.startBurst && !strobes.clearCounts) |=> (pulseCount >= $past(pulseCount))); // R8
  AST_SPAN_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.startBurst && !strobes.clearCounts) |=> (burstSpan >= $past(burstSpan))); // R9
  AST_HIT_HAS_SPAN: assert property (@(posedge clk) disable iff (!rstN)
    hit |-> (burstSpan != '0) && (pulseCount != '0 || prevLast)); // R6
endmodule

// File: rtl/glitch_burst_monitor.sv
module glitch_burst_monitor
  import gbm_pkg::*;
#(
  parameter int PHASES = 10,
  parameter int CNT_W  = 8,
  parameter int SPAN_W = 8,
  parameter int GAP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] phaseSamples,
  input  logic [GAP_W-1:0]  quietGap,
  output logic              hit,
  output logic [CNT_W-1:0]  pulseCount,
  output logic [SPAN_W-1:0] burstSpan,
  output logic              burstDone
);
  ctrlStrobe_t strobes;
  logic        hitNow;

  gbm_datapath #(.PHASES(PHASES), .CNT_W(CNT_W), .SPAN_W(SPAN_W)) i_datapath (
    .clk(clk), .rstN(rstN), .phaseSamples(phaseSamples), .strobes(strobes),
    .hitNow(hitNow), .hit(hit), .pulseCount(pulseCount), .burstSpan(burstSpan)
  );

  gbm_control #(.GAP_W(GAP_W)) i_control (
    .clk(clk), .rstN(rstN), .hitNow(hitNow), .quietGap(quietGap),
    .strobes(strobes), .burstDone(burstDone)
  );

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (burstDone && !hitNow) |=> (pulseCount == '0 && burstSpan == '0)); // R7
endmodule

// File: tb/test_glitch_burst_monitor.sv
module test_glitch_burst_monitor;
  localparam int PHASES = 10;
  localparam int CNT_W  = 5;
  localparam int SPAN_W = 5;
  localparam int GAP_W  = 3;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int SMAX   = (1 << SPAN_W) - 1;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [PHASES-1:0] phaseSamples = '0;
  logic [GAP_W-1:0]  quietGap = '0;
  logic              hit;
  logic [CNT_W-1:0]  pulseCount;
  logic [SPAN_W-1:0] burstSpan;
  logic              burstDone;

  int checks = 0;
  int errors = 0;

  // bench model state
  bit mActive, mDone, mPrev, mHit;
  int mQuiet, mPulse, mSpanRun, mSpan;

  always #2.5 clk = ~clk;

  glitch_burst_monitor #(.PHASES(PHASES), .CNT_W(CNT_W), .SPAN_W(SPAN_W), .GAP_W(GAP_W))
    i_glitch_burst_monitor (.clk(clk), .rstN(rstN), .phaseSamples(phaseSamples),
      .quietGap(quietGap), .hit(hit), .pulseCount(pulseCount), .burstSpan(burstSpan),
      .burstDone(burstDone));

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int risesOf(logic [PHASES-1:0] v, bit prev);
    int n = 0;
    for (int i = 0; i < PHASES; i++) begin
      bit lower = (i == 0) ? prev : v[i-1];
      if (v[i] && !lower) n++;
    end
    return n;
  endfunction

  // Apply one vector, advance one edge, update model, compare outputs.
  task automatic step(logic [PHASES-1:0] v, string hitTag, string cntTag);
    bit hitNow = |v;
    int e = risesOf(v, mPrev);
    int gapEff = (quietGap == 0) ? 1 : int'(quietGap);
    bit closeNow;
    @(negedge clk);
    phaseSamples = v;
    @(posedge clk);
    #1;
    closeNow = mActive && !hitNow && (mQuiet + 1 >= gapEff);
    if (!mActive && hitNow) begin
      mPulse = (e > CMAX) ? CMAX : e; mSpanRun = 1; mSpan = 1; mActive = 1; mQuiet = 0;
    end else if (mActive && hitNow) begin
      mPulse = (mPulse + e > CMAX) ? CMAX : mPulse + e;
      mSpanRun = (mSpanRun + 1 > SMAX) ? SMAX : mSpanRun + 1;
      mSpan = mSpanRun; mQuiet = 0;
    end else if (closeNow) begin
      mActive = 0; mQuiet = 0;
    end else if (mActive) begin
      mSpanRun = (mSpanRun + 1 > SMAX) ? SMAX : mSpanRun + 1; mQuiet++;
    end else if (mDone) begin
      mPulse = 0; mSpanRun = 0; mSpan = 0;
    end
    mDone = closeNow;
    mPrev = v[PHASES-1];
    mHit  = hitNow;
    check(hitTag, hit, mHit);
    check(cntTag, pulseCount, mPulse);
    check("R6 burstSpan", burstSpan, mSpan);
    check("R7 burstDone", burstDone, mDone);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    quietGap = 3'd2;
    #12;
    // R1: reset state
    check("R1 hit", hit, 0);
    check("R1 pulseCount", pulseCount, 0);
    check("R1 burstSpan", burstSpan, 0);
    check("R1 burstDone", burstDone, 0);
    @(negedge clk);
    rstN = 1'b1;

    // R3/R4: every single-cycle vector, then let the burst close
    for (int v = 0; v < (1 << PHASES); v++) begin
      bit single = ($countones(v) == 1);
      step(PHASES'(v), single ? "R3 hit" : "R2 hit", single ? "R3 pulseCount" : "R4 pulseCount");
      step('0, "R2 hit", "R4 pulseCount");
      step('0, "R2 hit", "R7 pulseCount");
      step('0, "R2 hit", "R7 pulseCount");
    end

    // R5: top bit high then bit 0 high -> one pulse across the boundary
    step(PHASES'(1) << (PHASES-1), "R5 hit", "R5 pulseCount");
    step(PHASES'(1), "R5 hit", "R5 pulseCount");
    check("R5 continued pulse", pulseCount, 1);
    step(PHASES'(2), "R5 hit", "R5 pulseCount");
    check("R5 new pulse", pulseCount, 2);
    for (int k = 0; k < 4; k++) step('0, "R2 hit", "R7 pulseCount");

    // R10: hit in the strobe cycle restarts a burst
    quietGap = 3'd1;
    step(10'b0000000110, "R10 hit", "R10 pulseCount");
    step('0, "R2 hit", "R7 pulseCount");
    check("R10 strobe", burstDone, 1);
    step(10'b0101000000, "R10 hit", "R10 pulseCount");
    check("R10 restart count", pulseCount, 2);
    check("R10 restart span", burstSpan, 1);
    step('0, "R2 hit", "R7 pulseCount");
    step('0, "R2 hit", "R7 pulseCount");

    // R8: alternating pattern, 5 pulses per cycle, saturates
    quietGap = 3'd3;
    for (int k = 0; k < 9; k++) step(10'b1010101010, "R2 hit", "R8 pulseCount");
    check("R8 saturated", pulseCount, CMAX);
    for (int k = 0; k < 4; k++) step('0, "R2 hit", "R7 pulseCount");

    // R9: long burst with short quiet holes saturates the span
    for (int k = 0; k < 45; k++) step((k % 3 == 2) ? '0 : '1, "R2 hit", "R4 pulseCount");
    check("R9 saturated", burstSpan, SMAX);
    for (int k = 0; k < 4; k++) step('0, "R2 hit", "R7 pulseCount");

    // R2/R4/R6/R7: pseudo-random sparse streams under every gap value
    for (int g = 0; g < (1 << GAP_W); g++) begin
      quietGap = GAP_W'(g);
      for (int k = 0; k < 600; k++) begin
        logic [PHASES-1:0] v;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        v = (lfsr[3:0] < 4'd6) ? PHASES'(lfsr[15:4] & {lfsr[9:0]}) : '0;
        step(v, "R2 hit", "R4 pulseCount");
      end
      for (int k = 0; k < 9; k++) step('0, "R2 hit", "R7 pulseCount");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule